// File: doc/BRIEF.md
# Audio Codec Error Status Tracker

This block sits between a stereo converter sample path and a host that moves samples through one-sample holding registers, one per direction. It watches both directions for timing faults. A capture sample that arrives while the previous one is still unread is dropped, and the held sample stays. A converter request for playback data when the host has supplied nothing new either repeats the last good sample or sends silence. Both faults are recorded as sticky flags.

The block also grades the loudness of every captured left and right sample into one of four bands around full scale. It places those grades, the live DMA request activity and the calibration state in a read-only error byte. A separate main status byte carries a summary error bit for a polling host. Reading the main status byte is the only way to clear the sticky flags. A plain read strobe with a one-bit select stands in for the host bus.

Top module: `audio_err_tracker`

## Requirements
- R1: After reset, both read bytes, both capture holding outputs and both DAC outputs are zero.
- R2: Let FS = 2^(SW-3), TLO = floor(FS*841/1000) and THI = floor(FS*1189/1000), with 8192, 6889 and 9740 for SW = 16. Each channel's absolute value A is graded 0 if A < TLO, 1 if A < FS, 2 if A <= THI, and 3 otherwise. Error byte bits [1:0] hold the left grade and bits [3:2] hold the right grade. Both are refreshed in the cycle after every capture strobe, including a strobe whose sample is dropped.
- R3: A capture strobe with an empty holding register loads the sample. A capture strobe with a full register and no host read in the same cycle keeps the old sample, discards the new one and sets the overrun flag (error byte bit 7).
- R4: A capture strobe in the same cycle as a host capture read loads the new sample and does not flag an overrun.
- R5: A DAC strobe while a host playback sample is pending drives that sample on the DAC outputs in the next cycle and consumes it.
- R6: A DAC strobe with no pending sample sets the underrun flag (error byte bit 6). With zero-fill at 0, it drives the last sample that was actually consumed.
- R7: A DAC strobe with no pending sample and zero-fill at 1 drives zero on both DAC outputs.
- R8: The overrun and underrun flags stay set through any number of error-byte reads (select 1). A main status read (select 0) clears them from the next cycle.
- R9: When a main status read and a new fault of the same kind fall in the same cycle, that flag remains set.
- R10: In the main status byte, bit 0 is the OR of the overrun and underrun flags, bit 1 shows that the capture holding register is full, bit 2 shows that a playback sample is pending, and bits 7..3 are zero.
- R11: Error byte bit 4 is the live OR of the two DMA request inputs, and bit 5 is the live calibration-busy input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_strobe | input | 1 | ADC produced a new stereo sample |
| cap_l | input | SW | ADC left sample, signed |
| cap_r | input | SW | ADC right sample, signed |
| host_cap_rd | input | 1 | Host takes the held capture sample |
| cap_l_q | output | SW | Held capture left sample |
| cap_r_q | output | SW | Held capture right sample |
| pb_wr | input | 1 | Host writes a playback sample |
| pb_l | input | SW | Host playback left sample |
| pb_r | input | SW | Host playback right sample |
| dac_strobe | input | 1 | DAC wants its next sample |
| zero_fill | input | 1 | Send silence on underrun |
| dac_l | output | SW | Sample sent to left DAC |
| dac_r | output | SW | Sample sent to right DAC |
| cap_drq | input | 1 | Capture DMA request active |
| pb_drq | input | 1 | Playback DMA request active |
| cal_busy | input | 1 | Auto-calibration running |
| rd_en | input | 1 | Host register read strobe |
| rd_sel | input | 1 | 0 selects main status, 1 selects error byte |
| rd_data | output | 8 | Selected byte, combinational |

## Verification
Two pairs of events can meet in one cycle. A fault can arrive as the host clears flags with a main status read. A capture strobe can arrive as the host takes the held sample. Both are set up in directed steps and also occur freely under the random mix, with strobes, reads and selects drawn independently each cycle. The outcome is judged against a bench model. In that model the new fault outlasts the clear, and a same-cycle read frees the register so the new sample lands with no overrun.

// File: rtl/audio_err_tracker.sv
module audio_err_tracker #(
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cap_strobe,
  input  logic signed [SW-1:0] cap_l,
  input  logic signed [SW-1:0] cap_r,
  input  logic                 host_cap_rd,
  output logic signed [SW-1:0] cap_l_q,
  output logic signed [SW-1:0] cap_r_q,
  input  logic                 pb_wr,
  input  logic signed [SW-1:0] pb_l,
  input  logic signed [SW-1:0] pb_r,
  input  logic                 dac_strobe,
  input  logic                 zero_fill,
  output logic signed [SW-1:0] dac_l,
  output logic signed [SW-1:0] dac_r,
  input  logic                 cap_drq,
  input  logic                 pb_drq,
  input  logic                 cal_busy,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  output logic [7:0]           rd_data
);
  localparam int FS  = 1 << (SW - 3);
  localparam int TLO = FS * 841 / 1000;
  localparam int THI = FS * 1189 / 1000;

  function automatic logic [1:0] grade(input logic signed [SW-1:0] s);
    logic [SW-1:0] a;
    a = s[SW-1] ? SW'(-s) : SW'(s);
    if (a < SW'(TLO))       grade = 2'd0;
    else if (a < SW'(FS))   grade = 2'd1;
    else if (a <= SW'(THI)) grade = 2'd2;
    else                    grade = 2'd3;
  endfunction

  logic cap_full, pb_full, cor, pur;
  logic [1:0] orl, orr;
  logic signed [SW-1:0] pb_hl, pb_hr, last_l, last_r;

  wire cap_take = cap_strobe & (~cap_full | host_cap_rd);
  wire ovr_evt  = cap_strobe & cap_full & ~host_cap_rd;
  wire unr_evt  = dac_strobe & ~pb_full;
  wire clr      = rd_en & ~rd_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_full <= 1'b0; pb_full <= 1'b0; cor <= 1'b0; pur <= 1'b0;
      orl <= 2'd0; orr <= 2'd0;
      cap_l_q <= '0; cap_r_q <= '0; pb_hl <= '0; pb_hr <= '0;
      last_l <= '0; last_r <= '0; dac_l <= '0; dac_r <= '0;
    end else begin
      if (cap_strobe) begin
        orl <= grade(cap_l);
        orr <= grade(cap_r);
      end
      if (cap_take) begin
        cap_l_q <= cap_l;
        cap_r_q <= cap_r;
      end
      cap_full <= cap_take | (cap_full & ~host_cap_rd);

      if (dac_strobe) begin
        if (pb_full) begin
          dac_l <= pb_hl; dac_r <= pb_hr;
          last_l <= pb_hl; last_r <= pb_hr;
        end else if (zero_fill) begin
          dac_l <= '0; dac_r <= '0;
        end else begin
          dac_l <= last_l; dac_r <= last_r;
        end
      end
      if (pb_wr) begin
        pb_hl <= pb_l; pb_hr <= pb_r;
      end
      pb_full <= pb_wr | (pb_full & ~dac_strobe);

      cor <= ovr_evt | (cor & ~clr);
      pur <= unr_evt | (pur & ~clr);
    end
  end

  wire [7:0] err_byte  = {cor, pur, cal_busy, cap_drq | pb_drq, orr, orl};
  wire [7:0] main_byte = {5'd0, pb_full, cap_full, cor | pur};
  assign rd_data = rd_sel ? err_byte : main_byte;

  // R3
  ovr_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe && cap_full && !host_cap_rd |=> cor && cap_l_q == $past(cap_l_q) && cap_r_q == $past(cap_r_q));
  // R4
  rd_and_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe && host_cap_rd |=> cap_full && cap_l_q == $past(cap_l));
  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cor || pur) && !clr |=> cor >= $past(cor) && pur >= $past(pur));
  // R8
  main_rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !cap_strobe && !dac_strobe |=> !cor && !pur);
  // R9
  race_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && ovr_evt |=> cor);
  // R7
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe && !pb_full && zero_fill |=> dac_l == '0 && dac_r == '0 && pur);
  // R5
  pb_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_strobe && pb_full && !pb_wr |=> !pb_full && dac_l == $past(pb_hl));
endmodule

// File: tb/test_audio_err_tracker.sv
`timescale 1ns/1ps
module test_audio_err_tracker;
  localparam int SW = 16;
  localparam int FS = 1 << (SW - 3);
  localparam int TLO = FS * 841 / 1000;
  localparam int THI = FS * 1189 / 1000;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cap_strobe = 0, host_cap_rd = 0, pb_wr = 0, dac_strobe = 0, zero_fill = 0;
  logic cap_drq = 0, pb_drq = 0, cal_busy = 0, rd_en = 0, rd_sel = 0;
  logic signed [SW-1:0] cap_l = 0, cap_r = 0, pb_l = 0, pb_r = 0;
  logic signed [SW-1:0] cap_l_q, cap_r_q, dac_l, dac_r;
  logic [7:0] rd_data;

  audio_err_tracker #(.SW(SW)) i_audio_err_tracker (
    .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .cap_l(cap_l), .cap_r(cap_r),
    .host_cap_rd(host_cap_rd), .cap_l_q(cap_l_q), .cap_r_q(cap_r_q),
    .pb_wr(pb_wr), .pb_l(pb_l), .pb_r(pb_r), .dac_strobe(dac_strobe), .zero_fill(zero_fill),
    .dac_l(dac_l), .dac_r(dac_r), .cap_drq(cap_drq), .pb_drq(pb_drq), .cal_busy(cal_busy),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data));

  int vecs = 0, errs = 0;
  string phase = "R1";
  logic m_cf = 0, m_pf = 0, m_cor = 0, m_pur = 0;
  logic [1:0] m_orl = 0, m_orr = 0;
  logic signed [SW-1:0] m_cl = 0, m_cr = 0, m_pl = 0, m_pr = 0, m_ll = 0, m_lr = 0, m_dl = 0, m_dr = 0;

  function automatic logic [1:0] ref_grade(input logic signed [SW-1:0] s);
    int a;
    a = (s < 0) ? -int'(s) : int'(s);
    if (a < TLO) return 2'd0;
    if (a < FS) return 2'd1;
    if (a <= THI) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic step(input logic cs, input logic signed [SW-1:0] cl, input logic signed [SW-1:0] cr,
                      input logic hr, input logic pw, input logic signed [SW-1:0] pl,
                      input logic signed [SW-1:0] pr, input logic ds, input logic zf,
                      input logic re, input logic rs, input logic cd, input logic pd, input logic cb);
    logic ovr, take, unr, clr;
    chk("R3 capture left hold", cap_l_q, m_cl);
    chk("R3 capture right hold", cap_r_q, m_cr);
    chk("R5 dac left", dac_l, m_dl);
    chk("R5 dac right", dac_r, m_dr);
    cap_strobe = cs; cap_l = cl; cap_r = cr; host_cap_rd = hr; pb_wr = pw; pb_l = pl; pb_r = pr;
    dac_strobe = ds; zero_fill = zf; rd_en = re; rd_sel = rs; cap_drq = cd; pb_drq = pd; cal_busy = cb;
    #1;
    if (rs) begin
      chk("R2 left grade", rd_data[1:0], m_orl);
      chk("R2 right grade", rd_data[3:2], m_orr);
      chk("R11 drq", rd_data[4], cd | pd);
      chk("R11 cal", rd_data[5], cb);
      chk("R6 underrun flag", rd_data[6], m_pur);
      chk("R3 overrun flag", rd_data[7], m_cor);
    end else begin
      chk("R10 main status", rd_data, {5'd0, m_pf, m_cf, m_cor | m_pur});
    end
    ovr = cs & m_cf & ~hr;
    take = cs & (~m_cf | hr);
    if (cs) begin m_orl = ref_grade(cl); m_orr = ref_grade(cr); end
    if (take) begin m_cl = cl; m_cr = cr; end
    m_cf = take | (m_cf & ~hr);
    unr = ds & ~m_pf;
    if (ds) begin
      if (m_pf) begin m_dl = m_pl; m_dr = m_pr; m_ll = m_pl; m_lr = m_pr; end
      else if (zf) begin m_dl = 0; m_dr = 0; end
      else begin m_dl = m_ll; m_dr = m_lr; end
    end
    if (pw) begin m_pl = pl; m_pr = pr; end
    m_pf = pw | (m_pf & ~ds);
    clr = re & ~rs;
    m_cor = ovr | (m_cor & ~clr);
    m_pur = unr | (m_pur & ~clr);
    @(negedge clk);
  endtask

  task automatic idle_rd(input logic rs);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, rs, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    phase = "R1";
    idle_rd(0); idle_rd(1);
    chk("R1 dac reset", dac_l, 0);

    phase = "R2";
    step(1, 16'sd6888, -16'sd6889, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    step(1, 16'sd8191, -16'sd8192, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    step(1, 16'sd9740, -16'sd9741, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    step(1, -16'sd32768, 16'sd0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    idle_rd(1);

    phase = "R3";
    step(1, 16'sd100, 16'sd200, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 16'sd9999, -16'sd9999, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    idle_rd(1); idle_rd(0);

    phase = "R8";
    idle_rd(1); idle_rd(1); idle_rd(0); idle_rd(1);

    phase = "R4";
    step(1, 16'sd300, 16'sd301, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    idle_rd(1);
    chk("R4 no overrun", rd_data[7], 0);

    phase = "R9";
    step(1, 16'sd5, 16'sd6, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    idle_rd(1);
    chk("R9 flag kept", rd_data[7], 1);
    idle_rd(0); idle_rd(1);

    phase = "R6";
    step(0, 0, 0, 1, 1, 16'sd1234, -16'sd1234, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0);
    chk("R6 repeat", dac_l, 1234);
    idle_rd(1);

    phase = "R7";
    step(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0);
    chk("R7 zero", dac_r, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 1, 0, 0, 0);
    chk("R6 last consumed", dac_l, 1234);

    phase = "R11";
    for (int k = 0; k < 8; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, k[0], k[1], k[2]);

    phase = "random";
    void'($urandom(32'd1234));
    for (int n = 0; n < 5000; n++) begin
      logic signed [SW-1:0] a, b, c, d;
      a = SW'($urandom_range(0, 12000)); if ($urandom_range(0, 1)) a = -a;
      b = SW'($urandom_range(0, 12000)); if ($urandom_range(0, 1)) b = -b;
      if ($urandom_range(0, 40) == 0) a = -16'sd32768;
      c = SW'($urandom); d = SW'($urandom);
      step($urandom_range(0, 2) == 0, a, b, $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, c, d, $urandom_range(0, 2) == 0, $urandom_range(0, 1),
           $urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule